// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block holds an alarm time for a real-time clock and watches the running calendar for it. Software programs a target second, minute, hour, day of week and day of month as BCD digits. The target sits in a register page that shares one 4-bit register bus with the calendar counters. Each field can be made a wildcard, so that only the chosen fields take part in the comparison. When every field still in play equals the live time on a time-update tick, the block latches a pending flag. If the interrupt enable is set, it raises a level interrupt.

The bus carries a page number and a register number with each access. This block answers only on its own page. Register numbers 0 to 8 are the alarm digits: 0/1 seconds, 2/3 minutes, 4/5 hours, 6 day of week, 7/8 day of month, ones digit at the lower number. Register 14 is the alarm control register. All other pages and register numbers belong to neighbouring logic. Reads are combinational. Writes take effect at the clock edge that samples them. The bus, the time vector and the interrupt are plain level signals with no handshake, because every access completes in one cycle and the time inputs are sampled only when `tick` is high.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, all nine alarm digit registers read 0, the control register reads 0 and `alarm_irq` is low.
- R2: With `bus_bank` = 1, a write to register 0..8 stores the 4-bit `bus_wdata`. Reads on page 1 return that digit on `bus_rdata` in the same cycle. Register 14 reads as {2'b00, pending flag (bit 1), interrupt enable (bit 0)}. Registers 9..13 and 15 read 0, and every register on other pages reads 0.
- R3: A write on a page other than 1, or to registers 9..13 or 15 of page 1, changes no alarm digit, the enable or the flag.
- R4: A field matches when its alarm value equals the live value in `now_time`. The ones digits (registers 0, 2, 4, 7) compare all 4 bits. The tens digits (1, 3, 5, 8) and the day of week (6) compare their low 3 bits against the whole live digit, which is taken to have bit 3 clear. Live digit i sits at `now_time[4i+3:4i]`.
- R5: Bit 3 of registers 1, 3, 5, 6 and 8 makes its field (seconds, minutes, hours, day of week, day of month) match whatever both of its live digits hold.
- R6: The flag is set at the clock edge of a cycle in which `tick` is high, all fields match, and at the previous tick (or, for the first tick after reset, at no earlier tick) the fields did not all match. It reads 1 from the next cycle on. Without `tick` the flag is never set.
- R7: The flag clears when register 14 is written with bit 1 = 0. Writing bit 1 = 1 leaves it unchanged. A clear and a set in the same cycle leave it set.
- R8: `alarm_irq` is high exactly while the flag and the enable are both 1. It follows them in the same cycle, with no added delay.
- R9: Any write to register 14 loads the interrupt enable from bit 0 of `bus_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_bank | input | 2 | Register page of the access |
| bus_addr | input | 4 | Register number within the page |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Combinational read data for bus_bank/bus_addr |
| now_time | input | 36 | Live time, nine BCD digits in register order |
| tick | input | 1 | High for one cycle when now_time has advanced |
| alarm_irq | output | 1 | Level interrupt: pending flag AND enable |

## Verification
A write or a tick sampled at one rising edge shows up from that edge onward. Digit readback, control readback and `alarm_irq` are therefore due in the cycle right after the stimulus cycle, while `bus_rdata` reflects a new address with no clock at all. The bench applies every stimulus at the falling edge and updates its reference model for that same edge. It compares `alarm_irq` 2 ns after the following rising edge, and it drives read addresses and compares `bus_rdata` 1 ns later still, well before the next falling edge. The directed part covers the single-cycle corners: a tick without a match, a repeated match, a wildcard field, a write of 1 to the flag, and a clear that coincides with a set. A seeded random phase then mixes writes on every page with near-miss times.

// File: rtl/alarm_match_pkg.sv
`timescale 1ns/1ps
package alarm_match_pkg;
  // Digit layout of the alarm page: sec(0,1) min(2,3) hour(4,5) wday(6) mday(7,8)
  localparam int NUM_DIGITS = 9;
  localparam int NUM_FIELDS = 5;

  // Lower digit index of a field (equal to upper for single-digit fields)
  function automatic int field_lo(input int f);
    case (f)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 6;
      default: return 7;
    endcase
  endfunction

  // Upper digit index of a field; this digit carries the wildcard bit
  function automatic int field_hi(input int f);
    case (f)
      0: return 1;
      1: return 3;
      2: return 5;
      3: return 6;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
`timescale 1ns/1ps
module alarm_regfile #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 9,
  parameter int ADDR_W     = 4,
  parameter int BANK_W     = 2,
  parameter int ALARM_BANK = 1,
  parameter int CTRL_ADDR  = 14
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [BANK_W-1:0]             bank,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wr_en,
  input  logic [DIGIT_W-1:0]            wdata,
  input  logic                          flag,
  input  logic                          ie,
  output logic [NUM_DIGITS*DIGIT_W-1:0] digits_o,
  output logic                          ctrl_wr,
  output logic [DIGIT_W-1:0]            rdata
);
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] dig_q;
  logic page_hit;

  assign page_hit = (bank == BANK_W'(ALARM_BANK));
  assign ctrl_wr  = wr_en && page_hit && (addr == ADDR_W'(CTRL_ADDR));
  assign digits_o = dig_q;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    always_ff @(posedge clk) begin
      if (!rst_n)
        dig_q[i] <= '0;
      else if (wr_en && page_hit && (addr == ADDR_W'(i)))
        dig_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (page_hit) begin
      if (addr == ADDR_W'(CTRL_ADDR))
        rdata = {{(DIGIT_W-2){1'b0}}, flag, ie};
      for (int i = 0; i < NUM_DIGITS; i++)
        if (addr == ADDR_W'(i))
          rdata = dig_q[i];
    end
  end
endmodule

// File: rtl/alarm_field_cmp.sv
`timescale 1ns/1ps
module alarm_field_cmp #(
  parameter int DIGIT_W   = 4,
  parameter bit TWO_DIGIT = 1'b1
) (
  input  logic [DIGIT_W-1:0] alarm_lo,
  input  logic [DIGIT_W-1:0] alarm_hi,
  input  logic [DIGIT_W-1:0] now_lo,
  input  logic [DIGIT_W-1:0] now_hi,
  output logic               hit
);
  localparam int MASK_BIT = DIGIT_W - 1;

  logic hi_eq;
  logic lo_eq;

  // Upper digit: wildcard bit read as 0 for the comparison
  assign hi_eq = ({1'b0, alarm_hi[MASK_BIT-1:0]} == now_hi);

  if (TWO_DIGIT) begin : g_pair
    assign lo_eq = (alarm_lo == now_lo);
  end else begin : g_single
    logic unused_lo;
    assign unused_lo = ^{alarm_lo, now_lo};
    assign lo_eq = 1'b1;
  end

  assign hit = alarm_hi[MASK_BIT] | (hi_eq & lo_eq);
endmodule

// File: rtl/alarm_flag_ctrl.sv
`timescale 1ns/1ps
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match_all,
  input  logic ctrl_wr,
  input  logic wr_ie,
  input  logic wr_flag,
  output logic flag_q,
  output logic ie_q,
  output logic prev_match_q,
  output logic irq
);
  logic set_evt;

  assign set_evt = tick & match_all & ~prev_match_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q       <= 1'b0;
      ie_q         <= 1'b0;
      prev_match_q <= 1'b0;
    end else begin
      if (tick)
        prev_match_q <= match_all;
      if (ctrl_wr)
        ie_q <= wr_ie;
      if (set_evt)
        flag_q <= 1'b1;
      else if (ctrl_wr && !wr_flag)
        flag_q <= 1'b0;
    end
  end

  assign irq = flag_q & ie_q;
endmodule

// File: rtl/alarm_match_unit.sv
`timescale 1ns/1ps
module alarm_match_unit
  import alarm_match_pkg::*;
#(
  parameter int DIGIT_W    = 4,
  parameter int ADDR_W     = 4,
  parameter int BANK_W     = 2,
  parameter int ALARM_BANK = 1,
  parameter int CTRL_ADDR  = 14
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [BANK_W-1:0]             bus_bank,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [DIGIT_W-1:0]            bus_wdata,
  output logic [DIGIT_W-1:0]            bus_rdata,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] now_time,
  input  logic                          tick,
  output logic                          alarm_irq
);
  localparam int TIME_W = NUM_DIGITS * DIGIT_W;

  logic [TIME_W-1:0]     alarm_digits;
  logic [NUM_FIELDS-1:0] field_hit;
  logic ctrl_wr, flag_q, ie_q, prev_match_q, match_all;

  alarm_regfile #(
    .DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS), .ADDR_W(ADDR_W),
    .BANK_W(BANK_W), .ALARM_BANK(ALARM_BANK), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bank(bus_bank), .addr(bus_addr),
    .wr_en(bus_wr), .wdata(bus_wdata), .flag(flag_q), .ie(ie_q),
    .digits_o(alarm_digits), .ctrl_wr(ctrl_wr), .rdata(bus_rdata)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam int LO = field_lo(f);
    localparam int HI = field_hi(f);
    alarm_field_cmp #(.DIGIT_W(DIGIT_W), .TWO_DIGIT(LO != HI)) u_cmp (
      .alarm_lo(alarm_digits[LO*DIGIT_W +: DIGIT_W]),
      .alarm_hi(alarm_digits[HI*DIGIT_W +: DIGIT_W]),
      .now_lo(now_time[LO*DIGIT_W +: DIGIT_W]),
      .now_hi(now_time[HI*DIGIT_W +: DIGIT_W]),
      .hit(field_hit[f])
    );
  end

  assign match_all = &field_hit;

  alarm_flag_ctrl u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick), .match_all(match_all),
    .ctrl_wr(ctrl_wr), .wr_ie(bus_wdata[0]), .wr_flag(bus_wdata[1]),
    .flag_q(flag_q), .ie_q(ie_q), .prev_match_q(prev_match_q), .irq(alarm_irq)
  );
endmodule

// File: rtl/alarm_match_checker.sv
`timescale 1ns/1ps
module alarm_match_checker #(
  parameter int DIGIT_W    = 4,
  parameter int ADDR_W     = 4,
  parameter int BANK_W     = 2,
  parameter int ALARM_BANK = 1,
  parameter int CTRL_ADDR  = 14,
  parameter int NUM_DIGITS = 9
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [BANK_W-1:0]             bus_bank,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_wr,
  input logic [DIGIT_W-1:0]            bus_wdata,
  input logic                          tick,
  input logic                          alarm_irq,
  input logic [NUM_DIGITS*DIGIT_W-1:0] alarm_digits,
  input logic                          match_all,
  input logic                          prev_match_q,
  input logic                          flag_q,
  input logic                          ie_q
);
  logic own_page, ctl_write, new_hit;
  assign own_page  = (bus_bank == BANK_W'(ALARM_BANK));
  assign ctl_write = bus_wr && own_page && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign new_hit   = tick && match_all && !prev_match_q;

  AST_DIGIT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && own_page && (bus_addr < ADDR_W'(NUM_DIGITS))
    |=> alarm_digits[$past(bus_addr)*DIGIT_W +: DIGIT_W] == $past(bus_wdata)); // R2
  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !own_page |=> $stable(alarm_digits) && $stable(ie_q)); // R3
  AST_SET_ON_NEW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    new_hit |=> flag_q); // R6
  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q && !tick |=> !flag_q); // R6
  AST_NO_SET_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q && tick && prev_match_q |=> !flag_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !(ctl_write && !bus_wdata[1]) |=> flag_q); // R7
  AST_CLEAR_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_write && !bus_wdata[1] && !new_hit |=> !flag_q); // R7
  AST_IRQ_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_write && !bus_wdata[0] |=> !alarm_irq); // R8
  AST_IRQ_ON_ENABLED_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    new_hit && ie_q && !ctl_write |=> alarm_irq); // R8
  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_write |=> ie_q == $past(bus_wdata[0])); // R9
endmodule

bind alarm_match_unit alarm_match_checker #(
  .DIGIT_W(DIGIT_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
  .ALARM_BANK(ALARM_BANK), .CTRL_ADDR(CTRL_ADDR), .NUM_DIGITS(NUM_DIGITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_bank(bus_bank), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .tick(tick), .alarm_irq(alarm_irq),
  .alarm_digits(alarm_digits), .match_all(match_all),
  .prev_match_q(prev_match_q), .flag_q(flag_q), .ie_q(ie_q)
);

// File: tb/alarm_match_unit_tb.sv
`timescale 1ns/1ps
module alarm_match_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  bus_bank = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_wdata = '0;
  logic [3:0]  bus_rdata;
  logic [35:0] now_time = '0;
  logic        tick = 1'b0;
  logic        alarm_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] m_reg [9];
  logic [3:0] m_now [9];
  logic m_ie, m_flag, m_prev;

  always #4 clk = ~clk;

  alarm_match_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_bank(bus_bank), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .now_time(now_time), .tick(tick), .alarm_irq(alarm_irq)
  );

  function automatic bit is_upper(input int i);
    return (i == 1) || (i == 3) || (i == 5) || (i == 6) || (i == 8);
  endfunction

  // Reference: field match from the requirement text (R4, R5)
  function automatic bit ref_field(input int lo, input int hi);
    if (m_reg[hi][3]) return 1'b1;
    if ({1'b0, m_reg[hi][2:0]} != m_now[hi]) return 1'b0;
    if (lo != hi && m_reg[lo] != m_now[lo]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit ref_match();
    return ref_field(0, 1) && ref_field(2, 3) && ref_field(4, 5) &&
           ref_field(6, 6) && ref_field(7, 8);
  endfunction

  function automatic logic [3:0] ref_read(input logic [1:0] b, input logic [3:0] a);
    if (b != 2'd1) return 4'h0;
    if (a < 4'd9) return m_reg[a];
    if (a == 4'd14) return {2'b00, m_flag, m_ie};
    return 4'h0;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; reference model advances for the same edge
  task automatic step(input bit wr, input logic [1:0] b, input logic [3:0] a,
                      input logic [3:0] d, input bit tk);
    bit hit, cw;
    @(negedge clk);
    bus_wr = wr; bus_bank = b; bus_addr = a; bus_wdata = d; tick = tk;
    for (int i = 0; i < 9; i++) now_time[i*4 +: 4] = m_now[i];
    hit = ref_match();
    cw = wr && b == 2'd1 && a == 4'd14;
    if (cw) m_ie = d[0];
    if (tk && hit && !m_prev) m_flag = 1'b1;
    else if (cw && !d[1]) m_flag = 1'b0;
    if (tk) m_prev = hit;
    if (wr && b == 2'd1 && a < 4'd9) m_reg[a] = d;
    @(posedge clk);
    #2;
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] b, input logic [3:0] a);
    bus_bank = b; bus_addr = a;
    #1;
    chk(tag, bus_rdata, ref_read(b, a));
  endtask

  task automatic irq_chk(input string tag);
    chk(tag, {3'b000, alarm_irq}, {3'b000, m_flag & m_ie});
  endtask

  task automatic now_equals_alarm();
    for (int i = 0; i < 9; i++) m_now[i] = is_upper(i) ? {1'b0, m_reg[i][2:0]} : m_reg[i];
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hang expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] t_reg [9];
    void'($urandom(32'd4242));
    for (int i = 0; i < 9; i++) begin m_reg[i] = '0; m_now[i] = 4'h9; end
    m_ie = 0; m_flag = 0; m_prev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;

    // R1: reset state
    irq_chk("R1 irq after reset");
    rd("R1 control after reset", 2'd1, 4'd14);
    for (int i = 0; i < 9; i++) rd("R1 digit after reset", 2'd1, 4'(i));

    // R2: program 12:34:56, weekday 3, day 21
    t_reg = '{4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd3, 4'd1, 4'd2};
    for (int i = 0; i < 9; i++) step(1, 2'd1, 4'(i), t_reg[i], 0);
    for (int i = 0; i < 9; i++) rd("R2 digit readback", 2'd1, 4'(i));
    rd("R2 unmapped register", 2'd1, 4'd11);
    rd("R2 other page read", 2'd0, 4'd0);

    // R3: foreign writes leave state alone
    step(1, 2'd0, 4'd1, 4'hF, 0);
    step(1, 2'd2, 4'd14, 4'h3, 0);
    step(1, 2'd1, 4'd10, 4'h7, 0);
    rd("R3 digit after foreign write", 2'd1, 4'd1);
    rd("R3 control after foreign write", 2'd1, 4'd14);

    // R6: matching time without tick does nothing
    now_equals_alarm();
    step(0, 2'd1, 4'd0, 4'h0, 0);
    rd("R6 no set without tick", 2'd1, 4'd14);

    // R9: enable interrupt
    step(1, 2'd1, 4'd14, 4'b0001, 0);
    rd("R9 enable set", 2'd1, 4'd14);
    irq_chk("R8 no irq before flag");

    // R6/R8: tick with match sets flag and irq
    step(0, 2'd1, 4'd0, 4'h0, 1);
    rd("R6 flag set on new match", 2'd1, 4'd14);
    irq_chk("R8 irq follows flag");

    // R7: clear, then repeated match does not re-set
    step(1, 2'd1, 4'd14, 4'b0001, 0);
    rd("R7 cleared by zero", 2'd1, 4'd14);
    irq_chk("R8 irq drops with flag");
    step(0, 2'd1, 4'd0, 4'h0, 1);
    rd("R6 repeated match no set", 2'd1, 4'd14);

    // R4: one ones digit off, then a tens digit off
    m_now[0] = 4'd7;
    step(0, 2'd1, 4'd0, 4'h0, 1);
    rd("R4 ones mismatch", 2'd1, 4'd14);
    m_now[0] = 4'd6; m_now[8] = 4'd3;
    step(0, 2'd1, 4'd0, 4'h0, 1);
    rd("R4 tens mismatch", 2'd1, 4'd14);

    // R5: wildcard on day of month ignores both digits
    m_now[7] = 4'd9;
    step(1, 2'd1, 4'd8, 4'b1010, 0);
    step(0, 2'd1, 4'd0, 4'h0, 1);
    rd("R5 wildcard field matches", 2'd1, 4'd14);

    // R7: write of 1 keeps flag; R9/R8: disable kills irq, keeps flag
    step(1, 2'd1, 4'd14, 4'b0011, 0);
    rd("R7 write one keeps flag", 2'd1, 4'd14);
    step(1, 2'd1, 4'd14, 4'b0010, 0);
    rd("R9 enable cleared", 2'd1, 4'd14);
    irq_chk("R8 irq off when disabled");

    // R7: clear and set in same cycle -> set
    m_now[0] = 4'd1;
    step(0, 2'd1, 4'd0, 4'h0, 1);
    step(1, 2'd1, 4'd14, 4'b0001, 0);
    rd("R7 cleared before race", 2'd1, 4'd14);
    m_now[0] = 4'd6;
    step(1, 2'd1, 4'd14, 4'b0001, 1);
    rd("R7 set wins over clear", 2'd1, 4'd14);
    irq_chk("R8 irq after race");

    // R5: day-of-week wildcard
    step(1, 2'd1, 4'd14, 4'b0000, 0);
    m_now[6] = 4'd5; m_now[0] = 4'd2;
    step(0, 2'd1, 4'd0, 4'h0, 1);
    step(1, 2'd1, 4'd6, 4'b1011, 0);
    m_now[0] = 4'd6;
    step(0, 2'd1, 4'd0, 4'h0, 1);
    rd("R5 weekday wildcard", 2'd1, 4'd14);

    // Random phase: writes on all pages, near-miss times, ticks
    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 3) begin
        logic [1:0] b;
        logic [3:0] a, d;
        b = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd1;
        a = ($urandom_range(0, 2) == 0) ? 4'd14 : 4'($urandom_range(0, 15));
        d = 4'($urandom_range(0, 15));
        if (a < 4'd9 && is_upper(int'(a)) && d[2:0] > 3'd5) d[2:0] = 3'd2;
        step(1, b, a, d, 0);
        rd("R3 random write readback", 2'd1, a);
      end else begin
        now_equals_alarm();
        if ($urandom_range(0, 2) != 0) begin
          int j;
          j = int'($urandom_range(0, 8));
          m_now[j] = m_now[j] ^ 4'd1;
        end
        step(($urandom_range(0, 7) == 0), 2'd1, 4'd14, 4'($urandom_range(0, 3)),
             ($urandom_range(0, 3) != 0));
        rd("R6 random flag state", 2'd1, 4'd14);
      end
      irq_chk("R8 random irq");
      if (n % 16 == 0) rd("R2 random digit", 2'd1, 4'($urandom_range(0, 8)));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule